// File: doc/BRIEF.md
# Configuration Register Field with Access Strobes

This block holds one control/status field of configurable width. It sits between a software access port and hardware logic. The software port is already decoded for this field: it presents a write enable, a read enable, a qualifier that marks a read as having a side effect, and write data. The hardware side can load a new value, clear the field, and always sees the stored value.

Hardware logic also receives a set of one-cycle status strobes, produced by a small access-tracking state machine. One strobe fires on any software access, one on any access that modifies, and one is a self-clearing pulse when software writes a 1 into bit 0. The block also provides the AND, OR and XOR reductions of the stored bits.

The tracker has five states, and each one holds the kind of software access seen in the previous cycle:
- `ACC_QUIET`: no access.
- `ACC_READ`: a plain read.
- `ACC_READ_SE`: a read with side effect.
- `ACC_WRITE_ZERO`: a write with bit 0 clear.
- `ACC_WRITE_ONE`: a write with bit 0 set.

On every clock the tracker moves to the state that matches the current inputs:
- A write, with or without a read, goes to `ACC_WRITE_ONE` or `ACC_WRITE_ZERO` according to data bit 0.
- A read with the qualifier set goes to `ACC_READ_SE`.
- A read without the qualifier goes to `ACC_READ`.
- No access goes to `ACC_QUIET`.

Reset forces `ACC_QUIET`.

Top module: `cfg_field`

## Requirements
- R1: A synchronous active-high reset loads the parameter RESET_VAL (default 8'hA5) into the field and drives the pulse, access and modify strobes low.
- R2: A software write loads the software write data into the field at the next clock edge.
- R3: A hardware write loads the hardware data at the next clock edge, but only when neither a software write nor a hardware clear is present in the same cycle.
- R4: A hardware clear sets every bit to 0 and takes priority over a hardware write. A software write in the same cycle takes priority over the clear.
- R5: The pulse output is high for exactly the one cycle after a software write whose data bit 0 is 1. A software write with bit 0 equal to 0 produces no pulse.
- R6: The access strobe is high for exactly the one cycle after any software read or write.
- R7: The modify strobe is high for exactly the one cycle after a software write, or after a software read that has the side-effect qualifier set. A plain read does not raise it, and the qualifier has no effect without the read enable.
- R8: The AND, OR and XOR outputs always equal the reductions of the current stored value.
- R9: With no software, hardware or reset activity, the stored value is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_wr_en | input | 1 | Software write enable |
| sw_rd_en | input | 1 | Software read enable |
| sw_rd_side | input | 1 | Marks a software read as having a side effect |
| sw_wdata | input | WIDTH | Software write data |
| hw_wr_en | input | 1 | Hardware write enable |
| hw_wdata | input | WIDTH | Hardware write data |
| hw_clr | input | 1 | Hardware clear |
| rd_value | output | WIDTH | Current stored value |
| pulse_o | output | 1 | One-cycle pulse after a software write of 1 in bit 0 |
| sw_acc_o | output | 1 | One-cycle strobe after any software access |
| sw_mod_o | output | 1 | One-cycle strobe after a modifying software access |
| and_o | output | 1 | AND reduction of the stored value |
| or_o | output | 1 | OR reduction of the stored value |
| xor_o | output | 1 | XOR reduction of the stored value |

## Verification
The hardest cases to reach are those where sources collide in a single cycle. These are a software write together with a hardware clear, a hardware clear together with a hardware write, and a read together with a write. Only in these cycles do the priority order and the tracker's choice of state show. The stimulus table drives each of these collisions as a single vector with chosen data, so that the data bit 0 and the losing source's value differ from the expected result. Directed steps then apply reset in the middle of activity, and raise the side-effect qualifier without a read enable.

// File: rtl/cfg_field_pkg.sv
package cfg_field_pkg;

    // Kind of software access seen in the previous cycle
    typedef enum logic [2:0] {
        ACC_QUIET      = 3'd0,
        ACC_READ       = 3'd1,
        ACC_READ_SE    = 3'd2,
        ACC_WRITE_ZERO = 3'd3,
        ACC_WRITE_ONE  = 3'd4
    } acc_state_e;

endpackage

// File: rtl/cfg_field_store.sv
module cfg_field_store #(
    parameter int                 WIDTH     = 8,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_wr_en,
    input  logic [WIDTH-1:0] sw_wdata,
    input  logic             hw_wr_en,
    input  logic [WIDTH-1:0] hw_wdata,
    input  logic             hw_clr,
    output logic [WIDTH-1:0] value_q
);

    logic [WIDTH-1:0] value_d;

    // Priority: software write, then hardware clear, then hardware write
    always_comb begin
        value_d = value_q;
        if (sw_wr_en) begin
            value_d = sw_wdata;
        end else if (hw_clr) begin
            value_d = '0;
        end else if (hw_wr_en) begin
            value_d = hw_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= RESET_VAL;
        end else begin
            value_q <= value_d;
        end
    end

endmodule

// File: rtl/cfg_field_strobe_fsm.sv
module cfg_field_strobe_fsm
    import cfg_field_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_wr_en,
    input  logic sw_rd_en,
    input  logic sw_rd_side,
    input  logic wdata_lsb,
    output logic pulse_o,
    output logic sw_acc_o,
    output logic sw_mod_o
);

    acc_state_e state_q;
    acc_state_e state_d;

    // Next state: classify this cycle's access
    always_comb begin
        if (sw_wr_en) begin
            state_d = wdata_lsb ? ACC_WRITE_ONE : ACC_WRITE_ZERO;
        end else if (sw_rd_en) begin
            state_d = sw_rd_side ? ACC_READ_SE : ACC_READ;
        end else begin
            state_d = ACC_QUIET;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        pulse_o  = 1'b0;
        sw_acc_o = 1'b0;
        sw_mod_o = 1'b0;
        unique case (state_q)
            ACC_QUIET: begin
            end
            ACC_READ: begin
                sw_acc_o = 1'b1;
            end
            ACC_READ_SE: begin
                sw_acc_o = 1'b1;
                sw_mod_o = 1'b1;
            end
            ACC_WRITE_ZERO: begin
                sw_acc_o = 1'b1;
                sw_mod_o = 1'b1;
            end
            ACC_WRITE_ONE: begin
                pulse_o  = 1'b1;
                sw_acc_o = 1'b1;
                sw_mod_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cfg_field_reduce.sv
module cfg_field_reduce #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] value,
    output logic             and_o,
    output logic             or_o,
    output logic             xor_o
);

    logic [WIDTH-1:0] and_c;
    logic [WIDTH-1:0] or_c;
    logic [WIDTH-1:0] xor_c;

    assign and_c[0] = value[0];
    assign or_c[0]  = value[0];
    assign xor_c[0] = value[0];

    // Running reductions across the bits
    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
        assign and_c[i] = and_c[i-1] & value[i];
        assign or_c[i]  = or_c[i-1]  | value[i];
        assign xor_c[i] = xor_c[i-1] ^ value[i];
    end

    assign and_o = and_c[WIDTH-1];
    assign or_o  = or_c[WIDTH-1];
    assign xor_o = xor_c[WIDTH-1];

endmodule

// File: rtl/cfg_field.sv
module cfg_field #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = 8'hA5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_wr_en,
    input  logic             sw_rd_en,
    input  logic             sw_rd_side,
    input  logic [WIDTH-1:0] sw_wdata,
    input  logic             hw_wr_en,
    input  logic [WIDTH-1:0] hw_wdata,
    input  logic             hw_clr,
    output logic [WIDTH-1:0] rd_value,
    output logic             pulse_o,
    output logic             sw_acc_o,
    output logic             sw_mod_o,
    output logic             and_o,
    output logic             or_o,
    output logic             xor_o
);

    logic [WIDTH-1:0] value_q;

    cfg_field_store #(
        .WIDTH     (WIDTH),
        .RESET_VAL (RESET_VAL)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .sw_wr_en (sw_wr_en),
        .sw_wdata (sw_wdata),
        .hw_wr_en (hw_wr_en),
        .hw_wdata (hw_wdata),
        .hw_clr   (hw_clr),
        .value_q  (value_q)
    );

    cfg_field_strobe_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sw_wr_en   (sw_wr_en),
        .sw_rd_en   (sw_rd_en),
        .sw_rd_side (sw_rd_side),
        .wdata_lsb  (sw_wdata[0]),
        .pulse_o    (pulse_o),
        .sw_acc_o   (sw_acc_o),
        .sw_mod_o   (sw_mod_o)
    );

    cfg_field_reduce #(
        .WIDTH (WIDTH)
    ) u_reduce (
        .value (value_q),
        .and_o (and_o),
        .or_o  (or_o),
        .xor_o (xor_o)
    );

    assign rd_value = value_q;

endmodule

// File: rtl/cfg_field_chk.sv
module cfg_field_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_wr_en,
    input logic             sw_rd_en,
    input logic             sw_rd_side,
    input logic [WIDTH-1:0] sw_wdata,
    input logic             hw_wr_en,
    input logic [WIDTH-1:0] hw_wdata,
    input logic             hw_clr,
    input logic [WIDTH-1:0] rd_value,
    input logic             pulse_o,
    input logic             sw_acc_o,
    input logic             sw_mod_o,
    input logic             or_o,
    input logic             and_o,
    input logic             xor_o
);

    p_sw_write_r2: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en |=> rd_value == $past(sw_wdata));

    p_hw_write_r3: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr_en && !hw_clr && hw_wr_en) |=> rd_value == $past(hw_wdata));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr_en && hw_clr) |=> rd_value == '0);

    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && sw_wdata[0]) |=> pulse_o);

    p_no_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        !(sw_wr_en && sw_wdata[0]) |=> !pulse_o);

    p_acc_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en || sw_rd_en) |=> sw_acc_o);

    p_no_acc_r6: assert property (@(posedge clk) disable iff (rst)
        !(sw_wr_en || sw_rd_en) |=> !sw_acc_o);

    p_mod_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en || (sw_rd_en && sw_rd_side)) |=> sw_mod_o);

    p_no_mod_r7: assert property (@(posedge clk) disable iff (rst)
        !(sw_wr_en || (sw_rd_en && sw_rd_side)) |=> !sw_mod_o);

    p_reduce_r8: assert property (@(posedge clk) disable iff (rst)
        (or_o == (rd_value != '0)) && (and_o == (rd_value == '1)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr_en && !hw_clr && !hw_wr_en) |=> $stable(rd_value));

endmodule

bind cfg_field cfg_field_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_wr_en   (sw_wr_en),
    .sw_rd_en   (sw_rd_en),
    .sw_rd_side (sw_rd_side),
    .sw_wdata   (sw_wdata),
    .hw_wr_en   (hw_wr_en),
    .hw_wdata   (hw_wdata),
    .hw_clr     (hw_clr),
    .rd_value   (rd_value),
    .pulse_o    (pulse_o),
    .sw_acc_o   (sw_acc_o),
    .sw_mod_o   (sw_mod_o),
    .or_o       (or_o),
    .and_o      (and_o),
    .xor_o      (xor_o)
);

// File: tb/cfg_field_tb.sv
`timescale 1ns/1ps
module cfg_field_tb;

    localparam int         W     = 8;
    localparam logic [7:0] RST_V = 8'hA5;
    localparam int         NVEC  = 14;

    // Vector layout (32 bits): sw_wr, sw_rd, side, sw_wdata, hw_wr, hw_wdata,
    // hw_clr, expected value, expected pulse, access, modify
    function automatic logic [31:0] vec(
        input logic sw, input logic rd, input logic sd, input logic [7:0] swd,
        input logic hw, input logic [7:0] hwd, input logic cl,
        input logic [7:0] ev, input logic ep, input logic ea, input logic em);
        return {sw, rd, sd, swd, hw, hwd, cl, ev, ep, ea, em};
    endfunction

    localparam logic [31:0] VECS [NVEC] = '{
        vec(1,0,0,8'h3C, 0,8'h00, 0, 8'h3C, 0,1,1), // write, bit0 = 0
        vec(0,0,0,8'h00, 0,8'h00, 0, 8'h3C, 0,0,0), // idle hold
        vec(1,0,0,8'h81, 0,8'h00, 0, 8'h81, 1,1,1), // write, bit0 = 1
        vec(0,1,0,8'h00, 0,8'h00, 0, 8'h81, 0,1,0), // plain read
        vec(0,1,1,8'h00, 0,8'h00, 0, 8'h81, 0,1,1), // side-effect read
        vec(0,0,0,8'h00, 1,8'hFF, 0, 8'hFF, 0,0,0), // hw write
        vec(0,0,0,8'h00, 1,8'h12, 1, 8'h00, 0,0,0), // clear beats hw write
        vec(0,0,0,8'h00, 1,8'h07, 0, 8'h07, 0,0,0), // hw write
        vec(1,0,0,8'h55, 0,8'h00, 1, 8'h55, 1,1,1), // sw write beats clear
        vec(1,0,0,8'hF0, 1,8'h0F, 0, 8'hF0, 0,1,1), // sw write beats hw write
        vec(0,0,1,8'h00, 0,8'h00, 0, 8'hF0, 0,0,0), // qualifier alone
        vec(1,1,0,8'h6B, 0,8'h00, 0, 8'h6B, 1,1,1), // read with write
        vec(0,0,0,8'hFE, 0,8'h00, 0, 8'h6B, 0,0,0), // data without enable
        vec(0,0,0,8'h00, 0,8'h00, 0, 8'h6B, 0,0,0)  // idle
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         sw_wr_en, sw_rd_en, sw_rd_side, hw_wr_en, hw_clr;
    logic [W-1:0] sw_wdata, hw_wdata, rd_value;
    logic         pulse_o, sw_acc_o, sw_mod_o, and_o, or_o, xor_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    cfg_field #(.WIDTH(W), .RESET_VAL(RST_V)) u_dut (
        .clk(clk), .rst(rst),
        .sw_wr_en(sw_wr_en), .sw_rd_en(sw_rd_en), .sw_rd_side(sw_rd_side),
        .sw_wdata(sw_wdata), .hw_wr_en(hw_wr_en), .hw_wdata(hw_wdata),
        .hw_clr(hw_clr), .rd_value(rd_value), .pulse_o(pulse_o),
        .sw_acc_o(sw_acc_o), .sw_mod_o(sw_mod_o),
        .and_o(and_o), .or_o(or_o), .xor_o(xor_o)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output against an expected value and strobes
    task automatic check_all(input string tag, input logic [7:0] ev,
                             input logic ep, input logic ea, input logic em);
        check({"R2/R3/R4 ", tag}, "value", rd_value, ev);
        check({"R5 ", tag}, "pulse", {7'd0, pulse_o}, {7'd0, ep});
        check({"R6 ", tag}, "access", {7'd0, sw_acc_o}, {7'd0, ea});
        check({"R7 ", tag}, "modify", {7'd0, sw_mod_o}, {7'd0, em});
        check({"R8 ", tag}, "and", {7'd0, and_o}, {7'd0, &ev});
        check({"R8 ", tag}, "or", {7'd0, or_o}, {7'd0, |ev});
        check({"R8 ", tag}, "xor", {7'd0, xor_o}, {7'd0, ^ev});
    endtask

    task automatic idle_inputs();
        sw_wr_en = 0; sw_rd_en = 0; sw_rd_side = 0; sw_wdata = '0;
        hw_wr_en = 0; hw_wdata = '0; hw_clr = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset value and quiet strobes
        check_all("R1 reset", RST_V, 0, 0, 0);
        rst = 1'b0;

        // Table walk: drive at a falling edge, check one rising edge later
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            v = VECS[i];
            sw_wr_en   = v[31];
            sw_rd_en   = v[30];
            sw_rd_side = v[29];
            sw_wdata   = v[28:21];
            hw_wr_en   = v[20];
            hw_wdata   = v[19:12];
            hw_clr     = v[11];
            @(negedge clk);
            check_all($sformatf("vec%0d", i), v[10:3], v[2], v[1], v[0]);
        end
        idle_inputs();

        // R5/R6/R7: strobes last only one cycle after a single access
        sw_wr_en = 1; sw_wdata = 8'h01;
        @(negedge clk);
        idle_inputs();
        check_all("R5 pulse high", 8'h01, 1, 1, 1);
        @(negedge clk);
        check_all("R5 pulse self-clears", 8'h01, 0, 0, 0);

        // R9: several idle cycles hold the value
        repeat (3) @(negedge clk);
        check_all("R9 hold", 8'h01, 0, 0, 0);

        // R1: reset in the middle of an access wins
        sw_wr_en = 1; sw_wdata = 8'h33; rst = 1'b1;
        @(negedge clk);
        idle_inputs();
        rst = 1'b0;
        check_all("R1 reset mid-write", RST_V, 0, 0, 0);

        // R4: all-ones then clear, with hw write pending
        hw_wr_en = 1; hw_wdata = 8'hFF;
        @(negedge clk);
        check_all("R3 hw ones", 8'hFF, 0, 0, 0);
        hw_clr = 1; hw_wdata = 8'hAA;
        @(negedge clk);
        idle_inputs();
        check_all("R4 clear", 8'h00, 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule